// File: doc/BRIEF.md
# Hill-Climbing Modulation Index Tracker

This block chooses the modulation index that drives the sine-triangle PWM of a single-stage, grid-tied photovoltaic inverter. It receives a stream of PV voltage and current samples, each qualified by a valid strobe. Between two grid-cycle start pulses it sums these samples and counts them. When the next start pulse arrives, it divides each sum by the count to get a whole-cycle mean. A full grid period is used for the mean so that the second-harmonic ripple that grid feeding puts on the PV side cancels out. The product of the two means is the cycle's power.

The tracker compares that power with the power it measured in the previous measured cycle. If the new power is not lower, the index steps again in the same direction. If it is lower, the step direction reverses. The index is then clamped to a window. The upper bound of the window keeps the converter in discontinuous conduction. The lower bound guarantees a minimum power transfer.

The index is updated only at a cycle start, and it holds for the whole of the next cycle. This keeps the inverter from injecting dc current into the grid. Lowering the index raises the PV operating voltage, so the step direction moves the operating point along the PV curve.

Top module: `mppt_po_ctrl`

## Requirements
- R1: After reset the index equals MMIN, the step direction is upward and the stored reference power is zero. As a result, the first measured cycle with any power raises the index by STEP.
- R2: A cycle's mean voltage is floor(sum of valid voltage samples / sample count), and its mean current is formed the same way. Its power is the product of the two means. A sample strobed in the same clock as the cycle start belongs to the new cycle. Samples beyond 2^CW-1 in one cycle are ignored.
- R3: The index changes only on the clock edge at which the cycle-start input is high. Between start pulses it holds its value.
- R4: If a cycle's power is greater than or equal to the reference power, the step keeps its direction. If the power is lower, the direction reverses. The cycle's power then becomes the new reference.
- R5: Each update moves the index by exactly STEP, except where clamping shortens the move.
- R6: The index never leaves the range MMIN to MMAX inclusive. A step that would cross a bound stops at that bound.
- R7: When an update leaves the index at MMAX while stepping upward, or at MMIN while stepping downward, the stored direction is reversed for the next cycle.
- R8: A cycle with zero valid samples leaves the index, the direction and the reference power unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Qualifies v_smp and i_smp in this clock |
| v_smp | input | VW | PV voltage sample, unsigned |
| i_smp | input | IW | PV current sample, unsigned |
| cyc_start | input | 1 | One-clock pulse marking the start of a grid cycle |
| m_idx | output | MW | Modulation index for the PWM reference |

## Verification
The index is registered on the edge that samples the cycle-start pulse, so a cycle's result is due one clock after the pulse is driven. The bench releases the pulse on the next falling edge and compares m_idx there against a model that tracks the sums, the reference power and the direction. On the first sample of each cycle, the bench also compares m_idx with the previous result. This confirms that the index does not move in the middle of a cycle. Samples are driven on falling edges, so each one is counted at the following rising edge. The sample that arrives with the pulse is credited to the next cycle in the model.

// File: rtl/mppt_pkg.sv
package mppt_pkg;

    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;

    function automatic dir_e dir_flip(input dir_e d);
        return (d == DIR_UP) ? DIR_DN : DIR_UP;
    endfunction

endpackage

// File: rtl/mppt_accum.sv
module mppt_accum #(
    parameter int VW = 12,
    parameter int IW = 12,
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_i,
    input  logic             vld_i,
    input  logic [VW-1:0]    v_i,
    input  logic [IW-1:0]    i_i,
    output logic [VW+CW-1:0] sum_v_o,
    output logic [IW+CW-1:0] sum_i_o,
    output logic [CW-1:0]    cnt_o
);
    localparam int SVW = VW + CW;
    localparam int SIW = IW + CW;
    localparam logic [CW-1:0] CNT_FULL = '1;

    logic [SVW-1:0] sv_q;
    logic [SIW-1:0] si_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv_q  <= '0;
            si_q  <= '0;
            cnt_q <= '0;
        end else if (cyc_i) begin
            sv_q  <= vld_i ? SVW'(v_i) : '0;
            si_q  <= vld_i ? SIW'(i_i) : '0;
            cnt_q <= vld_i ? CW'(1) : '0;
        end else if (vld_i && cnt_q != CNT_FULL) begin
            sv_q  <= sv_q + SVW'(v_i);
            si_q  <= si_q + SIW'(i_i);
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign sum_v_o = sv_q;
    assign sum_i_o = si_q;
    assign cnt_o   = cnt_q;

    // R2: a new cycle starts from an empty count unless a sample arrives with the pulse
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && !vld_i) |=> (cnt_o == '0));

    // R2: each valid sample inside a cycle adds exactly one to the count
    a_r2_count: assert property (@(posedge clk) disable iff (rst)
        (!cyc_i && vld_i && cnt_q != CNT_FULL) |=> (cnt_o == $past(cnt_o) + CW'(1)));

endmodule

// File: rtl/mppt_avg_power.sv
module mppt_avg_power #(
    parameter int VW = 12,
    parameter int IW = 12,
    parameter int CW = 8
) (
    input  logic [VW+CW-1:0] sum_v_i,
    input  logic [IW+CW-1:0] sum_i_i,
    input  logic [CW-1:0]    cnt_i,
    output logic [VW+IW-1:0] pwr_o
);
    localparam int SVW = VW + CW;
    localparam int SIW = IW + CW;
    localparam int PW  = VW + IW;

    logic [SVW-1:0] q_v;
    logic [SIW-1:0] q_i;
    logic [VW-1:0]  avg_v;
    logic [IW-1:0]  avg_i;

    always_comb begin
        if (cnt_i == '0) begin
            q_v = '0;
            q_i = '0;
        end else begin
            q_v = sum_v_i / SVW'(cnt_i);
            q_i = sum_i_i / SIW'(cnt_i);
        end
        avg_v = q_v[VW-1:0];
        avg_i = q_i[IW-1:0];
        pwr_o = PW'(avg_v) * PW'(avg_i);
    end

    // R2: a mean never exceeds the largest value one sample can hold
    always_comb begin
        a_r2_mean_fits: assert (q_v[SVW-1:VW] == '0 && q_i[SIW-1:IW] == '0);
    end

endmodule

// File: rtl/mppt_po_step.sv
module mppt_po_step
    import mppt_pkg::*;
#(
    parameter int PW   = 24,
    parameter int MW   = 10,
    parameter int MMIN = 64,
    parameter int MMAX = 900,
    parameter int STEP = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_i,
    input  logic          has_smp_i,
    input  logic [PW-1:0] pwr_i,
    output logic [MW-1:0] m_o
);
    localparam int XW = MW + 2;
    localparam logic [MW-1:0] M_LO = MW'(MMIN);
    localparam logic [MW-1:0] M_HI = MW'(MMAX);
    localparam logic signed [XW-1:0] X_LO = XW'(MMIN);
    localparam logic signed [XW-1:0] X_HI = XW'(MMAX);
    localparam logic signed [XW-1:0] X_ST = XW'(STEP);

    dir_e          dir_q, dir_t, dir_n;
    logic [MW-1:0] m_q, m_n;
    logic [PW-1:0] pref_q;
    logic signed [XW-1:0] raw;

    always_comb begin
        dir_t = (pwr_i >= pref_q) ? dir_q : dir_flip(dir_q);
        raw   = (dir_t == DIR_UP) ? ($signed({2'b00, m_q}) + X_ST)
                                  : ($signed({2'b00, m_q}) - X_ST);
        if (raw > X_HI)      m_n = M_HI;
        else if (raw < X_LO) m_n = M_LO;
        else                 m_n = raw[MW-1:0];
        if (m_n == M_HI && dir_t == DIR_UP)      dir_n = DIR_DN;
        else if (m_n == M_LO && dir_t == DIR_DN) dir_n = DIR_UP;
        else                                     dir_n = dir_t;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q    <= M_LO;
            dir_q  <= DIR_UP;
            pref_q <= '0;
        end else if (cyc_i && has_smp_i) begin
            m_q    <= m_n;
            dir_q  <= dir_n;
            pref_q <= pwr_i;
        end
    end

    assign m_o = m_q;

    // R6: index stays inside the conduction-mode window
    a_r6_in_window: assert property (@(posedge clk) disable iff (rst)
        (m_q >= M_LO) && (m_q <= M_HI));

    // R3: no movement without a cycle start
    a_r3_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
        !cyc_i |=> $stable(m_q));

    // R8: an empty cycle changes nothing
    a_r8_empty_cycle: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && !has_smp_i) |=> ($stable(m_q) && $stable(pref_q) && $stable(dir_q)));

    // R5: a single update moves by at most one step
    a_r5_step_size: assert property (@(posedge clk) disable iff (rst)
        cyc_i |=> ((int'(m_q) <= int'($past(m_q)) + STEP) &&
                   (int'(m_q) + STEP >= int'($past(m_q)))));

    // R7: sitting on the top bound after an upward step leaves the direction downward
    a_r7_turn_at_top: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && has_smp_i && dir_t == DIR_UP && m_n == M_HI) |=> (dir_q == DIR_DN));

endmodule

// File: rtl/mppt_po_ctrl.sv
module mppt_po_ctrl #(
    parameter int VW   = 12,
    parameter int IW   = 12,
    parameter int CW   = 8,
    parameter int MW   = 10,
    parameter int MMIN = 64,
    parameter int MMAX = 900,
    parameter int STEP = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [VW-1:0] v_smp,
    input  logic [IW-1:0] i_smp,
    input  logic          cyc_start,
    output logic [MW-1:0] m_idx
);
    localparam int PW = VW + IW;

    logic [VW+CW-1:0] sum_v;
    logic [IW+CW-1:0] sum_i;
    logic [CW-1:0]    cnt;
    logic [PW-1:0]    pwr;

    mppt_accum #(.VW(VW), .IW(IW), .CW(CW)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .cyc_i   (cyc_start),
        .vld_i   (smp_vld),
        .v_i     (v_smp),
        .i_i     (i_smp),
        .sum_v_o (sum_v),
        .sum_i_o (sum_i),
        .cnt_o   (cnt)
    );

    mppt_avg_power #(.VW(VW), .IW(IW), .CW(CW)) u_avg (
        .sum_v_i (sum_v),
        .sum_i_i (sum_i),
        .cnt_i   (cnt),
        .pwr_o   (pwr)
    );

    mppt_po_step #(.PW(PW), .MW(MW), .MMIN(MMIN), .MMAX(MMAX), .STEP(STEP)) u_step (
        .clk       (clk),
        .rst       (rst),
        .cyc_i     (cyc_start),
        .has_smp_i (cnt != '0),
        .pwr_i     (pwr),
        .m_o       (m_idx)
    );

endmodule

// File: tb/tb_mppt_po_ctrl.sv
module tb_mppt_po_ctrl;
    localparam int VW = 12, IW = 12, CW = 8, MW = 10;
    localparam int MMIN = 64, MMAX = 900, STEP = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic [VW-1:0] v_smp = '0;
    logic [IW-1:0] i_smp = '0;
    logic cyc_start = 1'b0;
    logic [MW-1:0] m_idx;

    int checks = 0;
    int errors = 0;

    longint em, ed, epp, sv, si, sn;

    always #10 clk = ~clk;

    mppt_po_ctrl #(.VW(VW), .IW(IW), .CW(CW), .MW(MW),
                   .MMIN(MMIN), .MMAX(MMAX), .STEP(STEP)) dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .v_smp(v_smp),
        .i_smp(i_smp), .cyc_start(cyc_start), .m_idx(m_idx));

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint clamp_idx(input longint x);
        if (x > MMAX) return MMAX;
        if (x < MMIN) return MMIN;
        return x;
    endfunction

    task automatic model_update();
        longint p, d, raw;
        if (sn == 0) return;
        p   = (sv / sn) * (si / sn);
        d   = (p >= epp) ? ed : 1 - ed;
        raw = (d == 1) ? em + STEP : em - STEP;
        em  = clamp_idx(raw);
        if (em == MMAX && d == 1)      ed = 0;
        else if (em == MMIN && d == 0) ed = 1;
        else                           ed = d;
        epp = p;
    endtask

    // one grid cycle: n samples, optional random values, optional sample with the pulse
    task automatic do_cycle(input int n, input int vb, input int ib, input bit rnd,
                            input bit coin, input string tag);
        int cv, ci;
        for (int k = 0; k < n; k++) begin
            if (rnd && $urandom_range(0, 3) == 0) begin
                @(negedge clk);
                smp_vld = 1'b0;
            end
            @(negedge clk);
            cv = rnd ? int'($urandom_range(0, 4095)) : vb;
            ci = rnd ? int'($urandom_range(0, 4095)) : ib;
            smp_vld = 1'b1;
            v_smp = VW'(cv);
            i_smp = IW'(ci);
            sv += cv; si += ci; sn++;
            if (k == 0) begin
                @(negedge clk);
                smp_vld = 1'b0;
                check("R3 index held mid-cycle", longint'(m_idx), em);
            end
        end
        @(negedge clk);
        cyc_start = 1'b1;
        smp_vld = coin;
        cv = rnd ? int'($urandom_range(0, 4095)) : 4000;
        ci = rnd ? int'($urandom_range(0, 4095)) : 4000;
        v_smp = VW'(cv);
        i_smp = IW'(ci);
        model_update();
        sv = 0; si = 0; sn = 0;
        if (coin) begin
            sv = cv; si = ci; sn = 1;
        end
        @(negedge clk);
        cyc_start = 1'b0;
        smp_vld = 1'b0;
        check(tag, longint'(m_idx), em);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        em = MMIN; ed = 1; epp = 0; sv = 0; si = 0; sn = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset index", longint'(m_idx), MMIN);

        // R1: reference zero and direction up, so any power steps up
        do_cycle(4, 100, 100, 1'b0, 1'b0, "R1 first step up");
        check("R5 step equals STEP", longint'(m_idx), MMIN + STEP);

        // R8: empty cycle
        do_cycle(0, 0, 0, 1'b0, 1'b0, "R8 empty cycle holds");

        // R6 R7: rising power climbs to the top bound, then turns
        for (int k = 0; k < 56; k++)
            do_cycle(3, 200 + k * 60, 4000, 1'b0, 1'b0, "R6 climb clamped");
        check("R6 at top bound or turned", longint'(m_idx), em);
        do_cycle(3, 3950, 4000, 1'b0, 1'b0, "R7 turn after top bound");

        // R4: lower power reverses direction
        do_cycle(3, 50, 50, 1'b0, 1'b0, "R4 lower power reverses");
        do_cycle(3, 50, 50, 1'b0, 1'b0, "R4 equal power keeps direction");

        // R2: sample coincident with the pulse counts to the new cycle
        do_cycle(3, 10, 10, 1'b0, 1'b1, "R2 coincident sample ahead");
        do_cycle(2, 10, 10, 1'b0, 1'b0, "R2 coincident sample credited");

        // R2: uneven sums and rounding
        do_cycle(5, 7, 3, 1'b0, 1'b0, "R2 small means");

        // descend to the bottom bound: falling power every cycle alternates, so use
        // a fresh reset and low power to stay near MMIN
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        em = MMIN; ed = 1; epp = 0; sv = 0; si = 0; sn = 0;
        do_cycle(2, 2000, 2000, 1'b0, 1'b0, "R1 after second reset");
        do_cycle(2, 100, 100, 1'b0, 1'b0, "R6 falls to bottom bound");
        do_cycle(2, 100, 100, 1'b0, 1'b0, "R7 turn after bottom bound");

        // random mixture
        for (int c = 0; c < 120; c++)
            do_cycle(int'($urandom_range(0, 30)), 0, 0, 1'b1,
                     bit'($urandom_range(0, 1)), "R4 random cycle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule